// File: doc/BRIEF.md
# Power Delivery Transmit Retry and Reset Sequencer

This block sits beside the transmit and receive framers of a Power Delivery style link and decides what goes on the wire after a packet ends. It receives an end-of-packet strobe for each packet it sends. On that strobe it starts a timer and waits for the link partner's acknowledgement. If the timer runs out, the block asks for the same packet again, up to a programmable retry limit. After the last retry it escalates to a soft reset packet. If the soft reset also goes unanswered, it escalates to a hard reset. A hard reset that cannot reach the wire because the line stays busy ends in a hard-fail pulse. An enable bit gates each escalation step. When a needed step is disabled, the block gives up with a failure pulse instead.

The block also schedules the acknowledgement reply for packets received from the partner. It raises a reply request a fixed, parameterised number of microseconds after the receive end-of-packet strobe. This runs independently of the transmit sequence. A command input forces a hard reset request at any time.

All timers run on a microsecond tick divided from the system clock. The divider restarts whenever a timed step begins, so every deadline is an exact number of clock cycles. Bit coding, CRC and the physical layer belong to other blocks.

Top module: `pd_retry_seq`

## Requirements
- R1: The acknowledge-wait timer starts when `tx_eop` is sampled. If no acknowledgement arrives, the resulting step (`retry_req`, `soft_req` or `fail_pulse`) pulses exactly ACK_US*CLK_PER_US+1 cycles after that sampling edge.
- R2: On expiry of a normal packet's wait, `retry_req` pulses when `cfg_retry_en` is 1 and fewer than `cfg_max_retry` retries have been made, and `retry_cnt` increments. The next `tx_eop` (the retransmission) restarts the wait.
- R3: An `rx_ack` sampled while waiting produces `ok_pulse` one cycle later, clears `retry_cnt` to 0 and returns the block to idle (`wait_ack` low).
- R4: When a normal packet's wait expires with the retries used up (or `cfg_retry_en` low) and `cfg_soft_en` is 1, `soft_req` pulses. The next `tx_eop` starts the soft reset's wait.
- R5: When the soft reset's wait expires and `cfg_hard_en` is 1, `hard_req` pulses one cycle after the expiry pulse slot, provided `line_busy` is low. No two of the sequencer's result pulses ever coincide.
- R6: While a hard reset is pending and `line_busy` is high, no `hard_req` is issued. `hard_req` follows one cycle after `line_busy` is sampled low. If the line is still busy HARD_US microseconds after the hard reset became pending, `hard_fail_pulse` fires instead.
- R7: `cmd_hard` in any state abandons the current sequence and makes a hard reset pending. With the line free, `hard_req` pulses two cycles after `cmd_hard` is driven, and no earlier timer produces a later step.
- R8: When a step is needed but its enable bit is 0 (soft step with `cfg_soft_en` low, hard step with `cfg_hard_en` low), `fail_pulse` pulses in the expiry slot and the block returns to idle.
- R9: `ack_req` pulses exactly REPLY_US*CLK_PER_US cycles after `rx_eop` is sampled, independently of the transmit sequence.
- R10: `rx_ack` outside an acknowledge wait and `tx_eop` while a hard reset is pending produce no output pulse.
- R11: After reset all request and pulse outputs are 0, `wait_ack` is 0 and `retry_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_eop | input | 1 | Pulse: last end-of-packet bit of a transmitted packet |
| rx_eop | input | 1 | Pulse: valid received packet ended |
| rx_ack | input | 1 | Pulse: acknowledgement packet received |
| line_busy | input | 1 | Line currently occupied |
| cfg_retry_en | input | 1 | Enable automatic retries |
| cfg_max_retry | input | 2 | Maximum retry count |
| cfg_soft_en | input | 1 | Enable automatic soft reset |
| cfg_hard_en | input | 1 | Enable automatic hard reset |
| cmd_hard | input | 1 | Pulse: force a hard reset |
| retry_req | output | 1 | Pulse: resend the last packet |
| ack_req | output | 1 | Pulse: send acknowledgement reply |
| soft_req | output | 1 | Pulse: send soft reset packet |
| hard_req | output | 1 | Pulse: send hard reset |
| ok_pulse | output | 1 | Pulse: packet acknowledged |
| fail_pulse | output | 1 | Pulse: sequence stopped, step disabled |
| hard_fail_pulse | output | 1 | Pulse: hard reset blocked by busy line |
| wait_ack | output | 1 | Waiting for an acknowledgement |
| retry_cnt | output | 2 | Retries made for the current packet |

## Verification
The acknowledgement reply for a received packet and the expiry step of a transmitted packet can pulse in the same cycle, because they run on separate counters. The bench provokes this by placing `rx_eop` so that the reply delay ends exactly on the retry slot. It expects both `ack_req` and `retry_req` in that one cycle. The scoreboard then judges the pair by matching each observed pulse against a time-ordered expectation of code and cycle.

// File: rtl/pd_retry_seq.sv
module pd_retry_seq #(
  parameter int CLK_PER_US = 250,
  parameter int ACK_US     = 1000,
  parameter int HARD_US    = 5000,
  parameter int REPLY_US   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_eop,
  input  logic       rx_eop,
  input  logic       rx_ack,
  input  logic       line_busy,
  input  logic       cfg_retry_en,
  input  logic [1:0] cfg_max_retry,
  input  logic       cfg_soft_en,
  input  logic       cfg_hard_en,
  input  logic       cmd_hard,
  output logic       retry_req,
  output logic       ack_req,
  output logic       soft_req,
  output logic       hard_req,
  output logic       ok_pulse,
  output logic       fail_pulse,
  output logic       hard_fail_pulse,
  output logic       wait_ack,
  output logic [1:0] retry_cnt
);
  localparam int TMAX = (ACK_US > HARD_US) ? ACK_US : HARD_US;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int RCYC = REPLY_US * CLK_PER_US;
  localparam int RW   = $clog2(RCYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_TXP, S_HARD} st_t;

  st_t           st, nxt;
  logic          soft_k, soft_nxt;
  logic [1:0]    cnt_nxt;
  logic [DW-1:0] div;
  logic [TW-1:0] tmr;
  logic          restart, us_tick, expired;
  logic          p_ok, p_retry, p_soft, p_hard, p_fail, p_hfail;
  logic          rpend;
  logic [RW-1:0] rcnt;

  assign us_tick  = (div == DW'(CLK_PER_US - 1));
  assign expired  = (tmr == TW'(ACK_US));
  assign wait_ack = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      div <= '0;
      tmr <= '0;
    end else if (us_tick) begin
      div <= '0;
      if (tmr != TW'(TMAX)) tmr <= tmr + TW'(1);
    end else begin
      div <= div + DW'(1);
    end
  end

  always_comb begin
    nxt = st; soft_nxt = soft_k; cnt_nxt = retry_cnt; restart = 1'b0;
    p_ok = 1'b0; p_retry = 1'b0; p_soft = 1'b0;
    p_hard = 1'b0; p_fail = 1'b0; p_hfail = 1'b0;
    if (cmd_hard) begin
      nxt = S_HARD; restart = 1'b1; cnt_nxt = 2'd0;
    end else begin
      case (st)
        S_IDLE: if (tx_eop) begin
          nxt = S_WAIT; restart = 1'b1; soft_nxt = 1'b0; cnt_nxt = 2'd0;
        end
        S_TXP: if (tx_eop) begin
          nxt = S_WAIT; restart = 1'b1;
        end
        S_WAIT:
          if (rx_ack) begin
            p_ok = 1'b1; cnt_nxt = 2'd0; nxt = S_IDLE;
          end else if (expired) begin
            if (!soft_k) begin
              if (cfg_retry_en && (retry_cnt < cfg_max_retry)) begin
                p_retry = 1'b1; cnt_nxt = retry_cnt + 2'd1; nxt = S_TXP;
              end else if (cfg_soft_en) begin
                p_soft = 1'b1; cnt_nxt = 2'd0; soft_nxt = 1'b1; nxt = S_TXP;
              end else begin
                p_fail = 1'b1; cnt_nxt = 2'd0; nxt = S_IDLE;
              end
            end else if (cfg_hard_en) begin
              nxt = S_HARD; restart = 1'b1;
            end else begin
              p_fail = 1'b1; nxt = S_IDLE;
            end
          end
        S_HARD:
          if (!line_busy) begin
            p_hard = 1'b1; nxt = S_IDLE;
          end else if (tmr == TW'(HARD_US)) begin
            p_hfail = 1'b1; nxt = S_IDLE;
          end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; soft_k <= 1'b0; retry_cnt <= 2'd0;
      ok_pulse <= 1'b0; retry_req <= 1'b0; soft_req <= 1'b0;
      hard_req <= 1'b0; fail_pulse <= 1'b0; hard_fail_pulse <= 1'b0;
    end else begin
      st <= nxt; soft_k <= soft_nxt; retry_cnt <= cnt_nxt;
      ok_pulse <= p_ok; retry_req <= p_retry; soft_req <= p_soft;
      hard_req <= p_hard; fail_pulse <= p_fail; hard_fail_pulse <= p_hfail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpend <= 1'b0; rcnt <= '0; ack_req <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      if (rx_eop) begin
        rpend <= 1'b1; rcnt <= '0;
      end else if (rpend) begin
        if (rcnt == RW'(RCYC - 1)) begin
          ack_req <= 1'b1; rpend <= 1'b0;
        end else begin
          rcnt <= rcnt + RW'(1);
        end
      end
    end
  end

  a_r1_step_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_req || soft_req) |-> $past(st == S_WAIT && tmr == TW'(ACK_US)));
  a_r3_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rx_ack && !cmd_hard) |=> (ok_pulse && retry_cnt == 2'd0 && !wait_ack));
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok_pulse, retry_req, soft_req, hard_req, fail_pulse, hard_fail_pulse}));
  a_r6_hfail_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hard_fail_pulse |-> $past(line_busy));
  a_r7_force_hard: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hard |=> (st == S_HARD && !retry_req && !soft_req));
  a_r9_reply_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(rpend));
endmodule

// File: tb/pd_retry_seq_bench.sv
`timescale 1ns/1ps
module pd_retry_seq_bench;
  localparam int C = 4, TA = 10, TH = 25, TR = 3;
  localparam int EXP = TA*C + 2;
  localparam int RPL = TR*C + 1;
  localparam int HFL = TH*C + 2;

  logic clk = 0, rst_n = 0;
  logic tx_eop = 0, rx_eop = 0, rx_ack = 0, line_busy = 0, cmd_hard = 0;
  logic cfg_retry_en = 1, cfg_soft_en = 1, cfg_hard_en = 1;
  logic [1:0] cfg_max_retry = 2'd2;
  logic retry_req, ack_req, soft_req, hard_req, ok_pulse, fail_pulse, hard_fail_pulse, wait_ack;
  logic [1:0] retry_cnt;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  int exp_code[$];
  int exp_cyc[$];

  pd_retry_seq #(.CLK_PER_US(C), .ACK_US(TA), .HARD_US(TH), .REPLY_US(TR)) u_pd_retry_seq (
    .clk, .rst_n, .tx_eop, .rx_eop, .rx_ack, .line_busy, .cfg_retry_en, .cfg_max_retry,
    .cfg_soft_en, .cfg_hard_en, .cmd_hard, .retry_req, .ack_req, .soft_req, .hard_req,
    .ok_pulse, .fail_pulse, .hard_fail_pulse, .wait_ack, .retry_cnt);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string req_of(int code);
    case (code)
      0: return "R9 ack_req";
      1: return "R3 ok_pulse";
      2: return "R2 retry_req";
      3: return "R4 soft_req";
      4: return "R5 hard_req";
      5: return "R8 fail_pulse";
      default: return "R6 hard_fail_pulse";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_ev(int code, int c);
    exp_code.push_back(code);
    exp_cyc.push_back(c);
  endtask

  always begin
    @(posedge clk); #1;
    if (rst_n) begin
      logic [6:0] obs;
      obs = {hard_fail_pulse, fail_pulse, hard_req, soft_req, retry_req, ok_pulse, ack_req};
      for (int i = 0; i < 7; i++) if (obs[i]) begin
        if (exp_code.size() == 0) begin
          check(0, {"R10 unexpected ", req_of(i)}, cyc, -1);
        end else begin
          int ec, et;
          ec = exp_code.pop_front();
          et = exp_cyc.pop_front();
          check(ec == i && et == cyc, req_of(ec), i*100000 + cyc, ec*100000 + et);
        end
      end
    end
  end

  task automatic drive(int which, output int d);
    @(negedge clk);
    case (which)
      0: tx_eop = 1;
      1: rx_eop = 1;
      2: rx_ack = 1;
      default: cmd_hard = 1;
    endcase
    d = cyc;
  endtask

  task automatic release_all();
    @(negedge clk);
    tx_eop = 0; rx_eop = 0; rx_ack = 0; cmd_hard = 0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      while (exp_code.size() > 0) begin
        check(0, req_of(exp_code[0]), -1, exp_cyc[0]);
        void'(exp_code.pop_front());
        void'(exp_cyc.pop_front());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4*150000);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int d, d2, d3, d4, dr;
    repeat (3) @(negedge clk);
    check({retry_req, ack_req, soft_req, hard_req, ok_pulse, fail_pulse, hard_fail_pulse, wait_ack} == 0,
          "R11 outputs", 1, 0);
    check(retry_cnt == 0, "R11 retry_cnt", retry_cnt, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R4 R5: retries, soft reset, then hard reset
    drive(0, d); expect_ev(2, d + EXP); release_all();
    @(negedge clk); check(wait_ack == 1, "R1 wait_ack", wait_ack, 1);
    wait_until(d + 50);
    check(retry_cnt == 1, "R2 retry_cnt", retry_cnt, 1);
    drive(0, d2); expect_ev(2, d2 + EXP); release_all();
    wait_until(d2 + 50);
    check(retry_cnt == 2, "R2 retry_cnt", retry_cnt, 2);
    drive(0, d3); expect_ev(3, d3 + EXP); release_all();
    wait_until(d3 + 50);
    drive(0, d4); expect_ev(4, d4 + EXP + 1); release_all();
    wait_until(d4 + 55);
    check(wait_ack == 0, "R5 idle", wait_ack, 0);

    // R3: acknowledgement after one retry
    drive(0, d); expect_ev(2, d + EXP); release_all();
    wait_until(d + 50);
    drive(0, d2); release_all();
    wait_until(d2 + 10);
    drive(2, d3); expect_ev(1, d3 + 1); release_all();
    @(negedge clk);
    check(retry_cnt == 0, "R3 retry_cnt", retry_cnt, 0);
    check(wait_ack == 0, "R3 wait_ack", wait_ack, 0);

    // R8: retries and soft reset disabled
    cfg_retry_en = 0; cfg_soft_en = 0;
    drive(0, d); expect_ev(5, d + EXP); release_all();
    wait_until(d + 50);
    // R8: soft reset enabled, hard disabled
    cfg_retry_en = 1; cfg_max_retry = 0; cfg_soft_en = 1; cfg_hard_en = 0;
    drive(0, d); expect_ev(3, d + EXP); release_all();
    wait_until(d + 50);
    drive(0, d2); expect_ev(5, d2 + EXP); release_all();
    wait_until(d2 + 50);
    cfg_max_retry = 2; cfg_hard_en = 1;

    // R6 R10: busy line until hard-fail; tx_eop ignored meanwhile
    line_busy = 1;
    drive(3, d); expect_ev(6, d + HFL); release_all();
    wait_until(d + 30);
    drive(0, d2); release_all();
    wait_until(d + HFL + 5);
    line_busy = 0;
    // R6: busy line freed before the deadline
    line_busy = 1;
    drive(3, d); release_all();
    wait_until(d + 19);
    @(negedge clk); line_busy = 0; d2 = cyc; expect_ev(4, d2 + 1);
    wait_until(d2 + 10);

    // R7: forced hard reset in the middle of a wait
    drive(0, d); release_all();
    wait_until(d + 4);
    drive(3, d2); expect_ev(4, d2 + 2); release_all();
    wait_until(d + 60);

    // R9: reply scheduling
    drive(1, d); expect_ev(0, d + RPL); release_all();
    wait_until(d + 20);

    // R10: acknowledgement while idle is ignored
    drive(2, d); release_all();
    repeat (5) @(negedge clk);
    check(wait_ack == 0 && retry_cnt == 0, "R10 idle unchanged", wait_ack, 0);

    // R9 with R2: reply and retry in the same cycle
    drive(0, d); release_all();
    wait_until(d + EXP - RPL - 1);
    drive(1, dr);
    if (dr + RPL <= d + EXP) begin expect_ev(0, dr + RPL); expect_ev(2, d + EXP); end
    else begin expect_ev(2, d + EXP); expect_ev(0, dr + RPL); end
    release_all();
    check(dr + RPL == d + EXP, "R9 same-cycle setup", dr + RPL, d + EXP);
    wait_until(d + 50);
    drive(0, d2); release_all();
    wait_until(d2 + 5);
    drive(2, d3); expect_ev(1, d3 + 1); release_all();
    repeat (5) @(negedge clk);
    check(retry_cnt == 0, "R3 retry_cnt after concurrency", retry_cnt, 0);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule